// File: doc/BRIEF.md
# Reloading Down-Counter Timer Bank

This block holds three independent down-counting timers behind a small 32-bit register bus. Two timers carry 16-bit counters and the third carries a 32-bit counter. Each one advances on a single-cycle enable strobe: either the fast tick or the slow tick, chosen per timer. When a timer passes zero it either reloads its stored period or wraps to its maximum count, and in both cases it raises a sticky interrupt flag.

Software programs a timer by clearing its run bit, writing the period, and then setting the run bit. A period written while the timer is stopped also goes straight into the counter, so the first period after start has the programmed length. Writing any value to a timer's clear register drops its flag. The bank drives one interrupt line per timer and an OR of all three.

Top module: `tmr_bank`

## Requirements
- R1: Timer bases are 0x00, 0x20 and 0x80. Inside each base, the period register is at +0x0, the count register at +0x4, the control register at +0x8 and the clear register at +0xC. Any other address, or any address with bits [1:0] not zero, reads as zero and ignores writes.
- R2: The control register holds bit 7 (run), bit 6 (reload on underflow) and bit 3 (count on the fast tick). These bits read back as last written. Every other bit reads as zero.
- R3: The period register reads back the last value written, truncated to the timer width. A period written while run is 0 is also copied into the counter. While run is 1, a period write leaves the counter unchanged.
- R4: While run is 1, the counter drops by one on each selected tick. It uses `tick_fast` when bit 3 is 1 and `tick_slow` when bit 3 is 0. The tick that is not selected has no effect.
- R5: While run is 0, ticks do not change the counter.
- R6: In reload mode (bit 6 = 1), a selected tick at count zero loads the counter from the period register.
- R7: In free-run mode (bit 6 = 0), a selected tick at count zero wraps the counter to all ones at its width: 0xFFFF for the 16-bit timers and 0xFFFFFFFF for the 32-bit timer.
- R8: Every underflow sets that timer's interrupt flag. The flag stays set until it is cleared.
- R9: A write of any value to a timer's clear register drops its flag. If an underflow happens in the same cycle, the flag stays set.
- R10: The count register reads the live count, zero-extended to 32 bits. The clear register reads as zero.
- R11: `irq_vec[i]` is the flag of timer i+1, and `irq_any` is high whenever any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_fast | input | 1 | Fast tick enable strobe |
| tick_slow | input | 1 | Slow tick enable strobe |
| irq_vec | output | 3 | Per-timer interrupt flags |
| irq_any | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the bank with the default widths of 16 and 32 bits. With these widths, small periods reach the wrap to 0xFFFF and to 0xFFFFFFFF within a few ticks, so the difference between the two widths is seen directly at the ports. The reference model runs each timer from integers masked to these widths. Directed cases cover the clear/underflow collision and a period of zero. A long stretch of random register traffic and random ticks then mixes mode changes with underflows that happen during writes.

// File: rtl/tmr_bank_pkg.sv
package tmr_bank_pkg;

    localparam int NUM_CH   = 3;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 8;

    localparam int BIT_RUN    = 7;
    localparam int BIT_RELOAD = 6;
    localparam int BIT_FAST   = 3;

    typedef enum logic [1:0] {
        OFF_PERIOD = 2'd0,
        OFF_COUNT  = 2'd1,
        OFF_CTRL   = 2'd2,
        OFF_CLEAR  = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic run;
        logic reload;
        logic fast;
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] ch_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] ctrl_pack(input ctrl_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[BIT_RUN]    = c.run;
        w[BIT_RELOAD] = c.reload;
        w[BIT_FAST]   = c.fast;
        return w;
    endfunction

endpackage

// File: rtl/tmr_bank_decode.sv
module tmr_bank_decode
    import tmr_bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] sel,
    output reg_off_e          off
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        localparam logic [ADDR_W-1:0] BASE = ch_base(g);
        assign sel[g] = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
    end

    assign off = reg_off_e'(addr[3:2]);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_bank_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_period,
    input  logic             wr_ctrl,
    input  logic             wr_clear,
    input  logic [CNT_W-1:0] period_in,
    input  ctrl_t            ctrl_in,
    input  logic             tick_fast,
    input  logic             tick_slow,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] count_q,
    output ctrl_t            ctrl_q,
    output logic             irq
);

    logic tick_sel;
    logic step;
    logic underflow;

    assign tick_sel  = ctrl_q.fast ? tick_fast : tick_slow;
    assign step      = ctrl_q.run && tick_sel;
    assign underflow = step && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            count_q  <= '0;
            ctrl_q   <= '0;
            irq      <= 1'b0;
        end else begin
            if (step) begin
                if (underflow)
                    count_q <= ctrl_q.reload ? period_q : {CNT_W{1'b1}};
                else
                    count_q <= count_q - 1'b1;
            end else if (wr_period && !ctrl_q.run) begin
                count_q <= period_in;
            end
            if (wr_period) period_q <= period_in;
            if (wr_ctrl)   ctrl_q   <= ctrl_in;
            if (underflow)     irq <= 1'b1;
            else if (wr_clear) irq <= 1'b0;
        end
    end

    // R8: flag holds until a clear write
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq && !wr_clear |=> irq);

    // R9: a clear without a same-cycle underflow drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        wr_clear && !underflow |=> !irq);

    // R6: reload mode takes the stored period at underflow
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        underflow && ctrl_q.reload |=> count_q == $past(period_q));

    // R7: free-run mode wraps to all ones
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        underflow && !ctrl_q.reload |=> &count_q);

    // R5: a stopped counter only moves on a period write
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run && !wr_period |=> $stable(count_q));

    // R3: a period write while stopped lands in the counter
    a_r3_copy: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run && wr_period |=> count_q == $past(period_in));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_bank_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic [NUM_CH-1:0] irq_vec,
    output logic              irq_any
);

    logic [NUM_CH-1:0]            sel;
    reg_off_e                     off;
    ctrl_t                        ctrl_wr;
    logic [NUM_CH-1:0][BUS_W-1:0] rd_period;
    logic [NUM_CH-1:0][BUS_W-1:0] rd_count;
    logic [NUM_CH-1:0][BUS_W-1:0] rd_ctrl;

    tmr_bank_decode u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .off  (off)
    );

    assign ctrl_wr = '{run: bus_wdata[BIT_RUN], reload: bus_wdata[BIT_RELOAD], fast: bus_wdata[BIT_FAST]};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int W = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
        logic [W-1:0] period_w;
        logic [W-1:0] count_w;
        ctrl_t        ctrl_w;

        tmr_chan #(.CNT_W(W)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_period (bus_we && sel[g] && off == OFF_PERIOD),
            .wr_ctrl   (bus_we && sel[g] && off == OFF_CTRL),
            .wr_clear  (bus_we && sel[g] && off == OFF_CLEAR),
            .period_in (bus_wdata[W-1:0]),
            .ctrl_in   (ctrl_wr),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .period_q  (period_w),
            .count_q   (count_w),
            .ctrl_q    (ctrl_w),
            .irq       (irq_vec[g])
        );

        assign rd_period[g] = 32'(period_w);
        assign rd_count[g]  = 32'(count_w);
        assign rd_ctrl[g]   = ctrl_pack(ctrl_w);
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                case (off)
                    OFF_PERIOD: bus_rdata = rd_period[i];
                    OFF_COUNT:  bus_rdata = rd_count[i];
                    OFF_CTRL:   bus_rdata = rd_ctrl[i];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq_any = |irq_vec;

    // R1: an address selects at most one timer
    a_r1_onehot_sel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R11: the combined line rises only when some flag is set
    a_r11_any_follows: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_any) |-> $countones(irq_vec) > 0);

endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/100ps
module tmr_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic [2:0]  irq_vec;
    logic        irq_any;

    int n_cmp = 0;
    int n_bad = 0;

    longint m_per[3];
    longint m_cnt[3];
    bit     m_run[3];
    bit     m_rel[3];
    bit     m_fast[3];
    bit     m_irq[3];

    always #2.5 clk = ~clk;

    tmr_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .irq_vec   (irq_vec),
        .irq_any   (irq_any)
    );

    function automatic longint wmask(int i);
        return (i == 2) ? 64'hFFFF_FFFF : 64'hFFFF;
    endfunction

    function automatic int chan_of(logic [7:0] a);
        if (a[1:0] != 2'b00) return -1;
        case (a[7:4])
            4'h0: return 0;
            4'h2: return 1;
            4'h8: return 2;
            default: return -1;
        endcase
    endfunction

    function automatic longint exp_read(logic [7:0] a);
        int c;
        c = chan_of(a);
        if (c < 0) return 0;
        case (a[3:2])
            2'd0: return m_per[c];
            2'd1: return m_cnt[c];
            2'd2: return (longint'(m_run[c]) << 7) | (longint'(m_rel[c]) << 6) | (longint'(m_fast[c]) << 3);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (chan_of(a) < 0) return "R1";
        case (a[3:2])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R2";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            m_per[i] = 0; m_cnt[i] = 0; m_run[i] = 0;
            m_rel[i] = 0; m_fast[i] = 0; m_irq[i] = 0;
        end
    endtask

    task automatic model_step(bit we, logic [7:0] a, logic [31:0] d, bit tf, bit ts);
        bit uf[3];
        bit clr[3];
        int c;
        for (int i = 0; i < 3; i++) begin
            uf[i] = 0; clr[i] = 0;
            if (m_run[i] && (m_fast[i] ? tf : ts)) begin
                if (m_cnt[i] == 0) begin
                    uf[i] = 1;
                    m_cnt[i] = m_rel[i] ? m_per[i] : wmask(i);
                end else begin
                    m_cnt[i] = m_cnt[i] - 1;
                end
            end
        end
        c = chan_of(a);
        if (we && c >= 0) begin
            case (a[3:2])
                2'd0: begin
                    m_per[c] = longint'(d) & wmask(c);
                    if (!m_run[c]) m_cnt[c] = m_per[c];
                end
                2'd2: begin
                    m_run[c] = d[7]; m_rel[c] = d[6]; m_fast[c] = d[3];
                end
                2'd3: clr[c] = 1;
                default: ;
            endcase
        end
        for (int i = 0; i < 3; i++) begin
            if (uf[i]) m_irq[i] = 1;
            else if (clr[i]) m_irq[i] = 0;
        end
    endtask

    task automatic step(bit we, logic [7:0] a, logic [31:0] d, bit tf, bit ts);
        bit any;
        bus_we = we; bus_addr = a; bus_wdata = d;
        tick_fast = tf; tick_slow = ts;
        #1;
        if (!we) chk(tag_of(a), longint'(bus_rdata), exp_read(a));
        any = 0;
        for (int i = 0; i < 3; i++) begin
            chk("R8/R9", longint'(irq_vec[i]), longint'(m_irq[i]));
            any |= m_irq[i];
        end
        chk("R11", longint'(irq_any), longint'(any));
        model_step(we, a, d, tf, ts);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, bit tf = 0, bit ts = 0);
        step(0, a, 32'h0, tf, ts);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, bit tf = 0, bit ts = 0);
        step(1, a, d, tf, ts);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // reset state of every register, plus unmapped addresses (R1, R10)
        for (int c = 0; c < 3; c++)
            for (int o = 0; o < 4; o++)
                rd(8'((c == 0 ? 0 : c == 1 ? 8'h20 : 8'h80) + o * 4));
        rd(8'h40); rd(8'h02);

        // R3/R6/R8: timer 1 reload mode on the fast tick, period 5
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h0001_0005);
        rd(8'h04);
        wr(8'h08, 32'hC8);
        for (int k = 0; k < 14; k++) rd(8'h04, 1, 0);
        rd(8'h0C);
        wr(8'h0C, 32'h1234);          // R9 plain clear
        rd(8'h04);
        // R3: period write while running leaves the count alone
        wr(8'h00, 32'h9, 0, 0);
        rd(8'h04); rd(8'h00);

        // R7 and R4: timer 2 free-run on the slow tick, fast ticks ignored
        wr(8'h28, 32'h0);
        wr(8'h20, 32'h3);
        wr(8'h28, 32'h80);
        for (int k = 0; k < 6; k++) rd(8'h24, 1, (k % 2) == 0);

        // R7 at 32 bits: timer 3 free-run on the fast tick
        wr(8'h88, 32'h0);
        wr(8'h80, 32'h1);
        wr(8'h88, 32'h88);
        for (int k = 0; k < 4; k++) rd(8'h84, 1, 1);

        // R2: only bits 7, 6, 3 are kept
        wr(8'h28, 32'hFFFF_FF37);
        rd(8'h28);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28);

        // R5: stopped timer ignores ticks
        wr(8'h88, 32'h0);
        for (int k = 0; k < 4; k++) rd(8'h84, 1, 1);

        // R9: clear collides with underflow (period 0 underflows on every tick)
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h08, 32'hC8);
        rd(8'h04, 1, 0);
        wr(8'h0C, 32'h0, 1, 0);
        rd(8'h04);
        wr(8'h0C, 32'h0, 0, 0);
        rd(8'h04);

        // R1: writes to unmapped or misaligned addresses are ignored
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h01, 32'hFFFF_FFFF);
        wr(8'h8A, 32'h0);
        rd(8'h00); rd(8'h08); rd(8'h88); rd(8'h40);

        // mixed random traffic across all requirements
        for (int k = 0; k < 4000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          c;
            c = $urandom % 4;
            a = (c == 0) ? 8'h00 : (c == 1) ? 8'h20 : (c == 2) ? 8'h80 : 8'h44;
            a = a + 8'(($urandom % 4) * 4);
            d = ($urandom % 4 == 0) ? $urandom : ($urandom % 8);
            if ($urandom % 3 == 0) d = d | 32'h80;
            step(($urandom % 4) == 0, a, d, ($urandom % 2) == 0, ($urandom % 5) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule